// File: doc/BRIEF.md
# Shared-Section Train Arbiter

Two trains, A and B, each run on their own loop, and the two loops meet in one section of track that only one train may use at a time. This block is a synchronous Moore machine that watches four proximity sensors, decides which train owns the shared section, and holds the other train until the section is clear. A sensor reads 1 while a train is near it and 0 otherwise. Each train has one approach sensor in front of the section and one exit sensor at its far end.

The block has three kinds of output. Two 2-bit motion commands tell each train to go, stop or reverse. A 2-bit junction value sets the track switches so that the shared section joins the loop of the train that owns it. The junction changes only when ownership passes to a train. It never moves under a train that is inside the section. If both trains reach their approach sensors in the same cycle, train A takes the section.

Top module: `track_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, both motion commands are 2'b10 (go), the junction is 2'b00 (track A) and the section is free.
- R2: The motion encoding is 2'b10 go, 2'b00 stop and 2'b01 reverse. The block only ever drives go or stop, so bit 0 of each command is always 0. A junction value of 2'b00 joins the section to track A and any nonzero value joins it to track B. The block drives 2'b11 for track B.
- R3: If the section is free and the A approach sensor is 1 at a clock edge, then from that edge the junction is 2'b00 and train A's command stays 2'b10.
- R4: If the section is free and only the B approach sensor is 1 at a clock edge, then from that edge the junction is 2'b11 and train B's command stays 2'b10.
- R5: If the section is free and both approach sensors are 1 at the same edge, train A takes the section and train B's command becomes 2'b00 from that edge.
- R6: If the other train's approach sensor is 1 while the section is occupied, and the occupant's exit sensor is 0 at that edge, the other train's command becomes 2'b00. It stays 2'b00 until the occupant's exit sensor is seen.
- R7: When the occupant's exit sensor is 1 and the other train is held, or its approach sensor is 1 at the same edge, the other train takes the section at that edge. The junction turns to that train's track and both commands read 2'b10.
- R8: When the occupant's exit sensor is 1 and no other train is waiting, the section becomes free, both commands read 2'b10 and the junction keeps its last value.
- R9: While a train occupies the section, the junction does not change at any edge where the occupant's exit sensor is 0.
- R10: The occupant's own approach sensor and the other train's exit sensor have no effect while the section is occupied. At no time are both trains commanded to stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| near_a_in | input | 1 | Train A approach sensor in front of the section |
| near_b_in | input | 1 | Train B approach sensor in front of the section |
| clear_a_in | input | 1 | Train A exit sensor at the far end of the section |
| clear_b_in | input | 1 | Train B exit sensor at the far end of the section |
| junction_o | output | 2 | Switch setting: 2'b00 track A, 2'b11 track B |
| cmd_a_o | output | 2 | Train A motion command (10 go, 00 stop, 01 reverse) |
| cmd_b_o | output | 2 | Train B motion command (10 go, 00 stop, 01 reverse) |

## Verification
The assertions take for granted that each sensor is a clean, synchronous level that is sampled once per clock. They place no constraint on sensor combinations, because the machine defines a response for all sixteen. Directed sequences walk through every ownership handover, including a simultaneous approach and an exit that coincides with the other train's approach. A long pseudo-random stretch then drives all four sensors freely, including physically impossible patterns such as the occupant's approach or the other train's exit firing mid-occupancy. This keeps the ignore rules under test as well.

// File: rtl/track_pkg.sv
package track_pkg;
  localparam int CMD_W = 2;
  localparam int JCT_W = 2;

  localparam logic [CMD_W-1:0] CMD_GO   = 2'b10;
  localparam logic [CMD_W-1:0] CMD_STOP = 2'b00;
  localparam logic [CMD_W-1:0] CMD_REV  = 2'b01;

  typedef enum logic [2:0] {
    ST_FREE     = 3'd0,
    ST_A        = 3'd1,
    ST_B        = 3'd2,
    ST_A_HOLD_B = 3'd3,
    ST_B_HOLD_A = 3'd4
  } sect_state_e;

  // motion command for one train given whether it is being held
  function automatic logic [CMD_W-1:0] motion_cmd(input logic held);
    return held ? CMD_STOP : CMD_GO;
  endfunction

  // junction value: all zeros selects track A, all ones selects track B
  function automatic logic [JCT_W-1:0] junction_code(input logic to_b);
    return to_b ? {JCT_W{1'b1}} : {JCT_W{1'b0}};
  endfunction

  function automatic logic a_inside(input sect_state_e s);
    return (s == ST_A) || (s == ST_A_HOLD_B);
  endfunction

  function automatic logic b_inside(input sect_state_e s);
    return (s == ST_B) || (s == ST_B_HOLD_A);
  endfunction
endpackage

// File: rtl/track_fsm.sv
module track_fsm
  import track_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        near_a,
  input  logic        near_b,
  input  logic        clear_a,
  input  logic        clear_b,
  output sect_state_e state,
  output logic        grant_a,
  output logic        grant_b,
  output logic        occupied,
  output logic        exit_evt,
  output logic        held
);
  sect_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FREE: begin
        if (near_a)      nxt = near_b ? ST_A_HOLD_B : ST_A;
        else if (near_b) nxt = ST_B;
      end
      ST_A: begin
        if (clear_a)     nxt = near_b ? ST_B : ST_FREE;
        else if (near_b) nxt = ST_A_HOLD_B;
      end
      ST_A_HOLD_B: begin
        if (clear_a)     nxt = ST_B;
      end
      ST_B: begin
        if (clear_b)     nxt = near_a ? ST_A : ST_FREE;
        else if (near_a) nxt = ST_B_HOLD_A;
      end
      ST_B_HOLD_A: begin
        if (clear_b)     nxt = ST_A;
      end
      default:           nxt = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FREE;
    else        state <= nxt;
  end

  // events brought out for the junction register and the checker
  assign grant_a  = a_inside(nxt) && !a_inside(state);
  assign grant_b  = b_inside(nxt) && !b_inside(state);
  assign occupied = (state != ST_FREE);
  assign exit_evt = (a_inside(state) && clear_a) || (b_inside(state) && clear_b);
  assign held     = (state == ST_A_HOLD_B) || (state == ST_B_HOLD_A);
endmodule

// File: rtl/track_junction.sv
module track_junction
  import track_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_a,
  input  logic             grant_b,
  output logic [JCT_W-1:0] junction
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       junction <= junction_code(1'b0);
    else if (grant_a) junction <= junction_code(1'b0);
    else if (grant_b) junction <= junction_code(1'b1);
  end
endmodule

// File: rtl/track_outputs.sv
module track_outputs
  import track_pkg::*;
(
  input  sect_state_e      state,
  output logic [CMD_W-1:0] cmd_a,
  output logic [CMD_W-1:0] cmd_b
);
  assign cmd_a = motion_cmd(state == ST_B_HOLD_A);
  assign cmd_b = motion_cmd(state == ST_A_HOLD_B);
endmodule

// File: rtl/track_arbiter.sv
module track_arbiter
  import track_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             near_a_in,
  input  logic             near_b_in,
  input  logic             clear_a_in,
  input  logic             clear_b_in,
  output logic [JCT_W-1:0] junction_o,
  output logic [CMD_W-1:0] cmd_a_o,
  output logic [CMD_W-1:0] cmd_b_o
);
  sect_state_e state;
  logic grant_a_w, grant_b_w, occ_w, exit_w, held_w;

  track_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .near_a(near_a_in), .near_b(near_b_in),
    .clear_a(clear_a_in), .clear_b(clear_b_in),
    .state(state), .grant_a(grant_a_w), .grant_b(grant_b_w),
    .occupied(occ_w), .exit_evt(exit_w), .held(held_w)
  );

  track_junction u_jct (
    .clk(clk), .rst_n(rst_n),
    .grant_a(grant_a_w), .grant_b(grant_b_w),
    .junction(junction_o)
  );

  track_outputs u_out (
    .state(state), .cmd_a(cmd_a_o), .cmd_b(cmd_b_o)
  );
endmodule

// File: rtl/track_arbiter_chk.sv
module track_arbiter_chk
  import track_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             near_a_in,
  input logic             near_b_in,
  input logic [JCT_W-1:0] junction_o,
  input logic [CMD_W-1:0] cmd_a_o,
  input logic [CMD_W-1:0] cmd_b_o,
  input logic             occ_w,
  input logic             exit_w,
  input logic             held_w
);
  // R2
  only_go_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_a_o[0] == 1'b0) && (cmd_b_o[0] == 1'b0));

  // R3
  grant_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!occ_w && near_a_in) |=> (junction_o == '0 && cmd_a_o == CMD_GO));

  // R4
  grant_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!occ_w && near_b_in && !near_a_in) |=> (junction_o == '1 && cmd_b_o == CMD_GO));

  // R5
  tie_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!occ_w && near_a_in && near_b_in) |=> (cmd_b_o == CMD_STOP));

  // R7
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_w && exit_w) |=> (cmd_a_o == CMD_GO && cmd_b_o == CMD_GO));

  // R9
  junction_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_w && !exit_w) |=> $stable(junction_o));

  // R10
  never_both_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_a_o == CMD_STOP && cmd_b_o == CMD_STOP));
endmodule

bind track_arbiter track_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .near_a_in(near_a_in), .near_b_in(near_b_in),
  .junction_o(junction_o), .cmd_a_o(cmd_a_o), .cmd_b_o(cmd_b_o),
  .occ_w(occ_w), .exit_w(exit_w), .held_w(held_w)
);

// File: tb/track_arbiter_bench.sv
`timescale 1ns/1ps
module track_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic na = 1'b0, nb = 1'b0, ca = 1'b0, cb = 1'b0;
  logic [1:0] jct, cmda, cmdb;

  always #2.5 clk = ~clk;

  track_arbiter u_track_arbiter (
    .clk(clk), .rst_n(rst_n),
    .near_a_in(na), .near_b_in(nb), .clear_a_in(ca), .clear_b_in(cb),
    .junction_o(jct), .cmd_a_o(cmda), .cmd_b_o(cmdb)
  );

  int checks = 0;
  int errors = 0;

  // reference model: who is inside (0 none, 1 A, 2 B), who waits, switch side
  int owner  = 0;
  int waiter = 0;
  bit on_b   = 0;

  function automatic logic [1:0] exp_cmd_a();
    return (owner == 2 && waiter == 1) ? 2'b00 : 2'b10;
  endfunction
  function automatic logic [1:0] exp_cmd_b();
    return (owner == 1 && waiter == 2) ? 2'b00 : 2'b10;
  endfunction
  function automatic logic [1:0] exp_jct();
    return on_b ? 2'b11 : 2'b00;
  endfunction

  task automatic model_edge(bit a, bit b, bit xa, bit xb);
    if (owner == 0) begin
      if (a) begin owner = 1; on_b = 0; waiter = b ? 2 : 0; end
      else if (b) begin owner = 2; on_b = 1; end
    end else if (owner == 1) begin
      if (xa) begin
        if (waiter == 2 || b) begin owner = 2; on_b = 1; end
        else owner = 0;
        waiter = 0;
      end else if (b) waiter = 2;
    end else begin
      if (xb) begin
        if (waiter == 1 || a) begin owner = 1; on_b = 0; end
        else owner = 0;
        waiter = 0;
      end else if (a) waiter = 1;
    end
  endtask

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "cmd_a", cmda, exp_cmd_a());
    check(tag, "cmd_b", cmdb, exp_cmd_b());
    check(tag, "junction", jct, exp_jct());
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic step(string tag, bit a, bit b, bit xa, bit xb);
    na = a; nb = b; ca = xa; cb = xb;
    @(posedge clk);
    model_edge(a, b, xa, xb);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    bit [15:0] lfsr;
    @(negedge clk);
    check_all("R1_in_reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1_after_reset");

    // A alone in and out
    step("R3_grant_a", 1, 0, 0, 0);
    step("R10_own_approach_ignored", 1, 0, 0, 1);
    step("R8_a_exit_free", 0, 0, 1, 0);
    // B alone in, A approaches and is held
    step("R4_grant_b", 0, 1, 0, 0);
    step("R6_hold_a", 1, 0, 0, 0);
    step("R6_a_still_held", 0, 0, 1, 0);
    step("R7_handover_to_a", 0, 0, 0, 1);
    step("R8_a_exit_keep_junction", 0, 0, 1, 0);
    // tie
    step("R5_tie_a_wins", 1, 1, 0, 0);
    step("R9_junction_steady", 0, 1, 0, 1);
    step("R7_handover_to_b", 0, 0, 1, 0);
    // exit coinciding with the other approach
    step("R7_exit_with_approach", 1, 0, 0, 1);
    step("R8_exit_free", 0, 0, 1, 0);
    step("R2_idle", 0, 0, 0, 0);
    check("R2", "cmd_a bit0", {1'b0, cmda[0]}, 2'b00);

    // free-running sensors
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R10_random", lfsr[0] & lfsr[5], lfsr[1] & lfsr[7], lfsr[2] & lfsr[9], lfsr[3] & lfsr[11]);
      check("R2", "cmd_b bit0", {1'b0, cmdb[0]}, 2'b00);
    end

    // reset mid-occupancy
    step("R6_setup", 0, 1, 0, 0);
    rst_n = 1'b0;
    owner = 0; waiter = 0; on_b = 0;
    @(negedge clk);
    check_all("R1_reset_again");
    rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule